// File: doc/BRIEF.md
# Slow-Rate Infrared Receive Unwrap Filter

This block sits between a slow-rate infrared UART receiver and the receive FIFO. It watches the incoming byte stream for frame delimiters and throws away wake-up header bytes, delimiters and escape codes. It forwards only the frame payload, which still carries its trailing 16-bit FCS, as a byte stream marked with a start-of-frame flag. At the end of each frame it raises a one-cycle end marker. The marker carries the frame's final byte count and its error flags.

A live byte count tracks the frame being received and gives the receive path a way to tell whether a packet is in flight. A 12-bit maximum length caps how many bytes are forwarded. The filter is active in slow-rate mode and can also be forced on by a test bit when another mode is selected. The fixed delimiter codes can be read on a 16-bit port.

Top module: `sir_unwrap`

## Requirements
- R1: After reset there is no data or end-marker pulse and `byte_count` is 0. The filter starts outside a frame, so the first bytes are ignored until a frame start arrives.
- R2: `delim_word` reads 16'hC1C0. The frame start code 0xC0 is in bits [7:0] and the frame end code 0xC1 is in bits [15:8].
- R3: Bytes that arrive outside a frame, such as header fill, produce no output and leave `byte_count` unchanged.
- R4: Each payload byte inside a frame appears on `out_data` with `out_valid` high one cycle after it is accepted. The first forwarded byte of a frame also has `out_sof` high.
- R5: The escape code 0x7D is removed. The byte that follows it is forwarded XOR 0x20.
- R6: `byte_count` rises by one for each forwarded byte only. It is set to 0 when a frame start code is accepted.
- R7: A frame end code that closes a frame with content pulses `out_eof` for one cycle. In that cycle `end_len` equals the final count and `end_flags` is 0 unless an error occurred.
- R8: Repeated frame start codes before the first payload byte are discarded. A frame that closes with no payload and no error produces no end marker.
- R9: A frame start code that arrives in a frame with content closes that frame with `end_flags` bit 1 (missing end) set, and opens a new frame with count 0.
- R10: Payload bytes beyond `max_len` are neither forwarded nor counted. The frame's end marker then has `end_flags` bit 0 (length error) set.
- R11: The filter is enabled when `sir_mode` or `filt_test` is high. While both are low, bytes are ignored and any open frame is abandoned without an end marker.
- R12: A delimiter code that follows an escape still acts as a delimiter and is not unescaped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Received byte present this cycle |
| in_byte | input | 8 | Received byte |
| sir_mode | input | 1 | Slow-rate mode selected |
| filt_test | input | 1 | Force filter on outside slow-rate mode |
| max_len | input | LEN_W | Maximum payload bytes accepted per frame |
| out_valid | output | 1 | Forwarded payload byte strobe |
| out_data | output | 8 | Forwarded payload byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eof | output | 1 | One-cycle end-of-frame marker |
| byte_count | output | LEN_W | Live count of the current frame's forwarded bytes |
| end_len | output | LEN_W | Final count, valid with out_eof |
| end_flags | output | 2 | bit0 length error, bit1 missing end; valid with out_eof |
| delim_word | output | 16 | Fixed delimiter readback |

## Verification
Every result is due one cycle after its byte is accepted. A byte driven before a rising edge shows its data, start flag, end marker and new count just after that edge, and `end_len` and `end_flags` are qualified by the marker in that same cycle. The bench drives each byte on the falling edge and compares every output a quarter period after the next rising edge. It uses a running model of the expected frame state, so each pulse is checked in exactly its one valid cycle. The idle cycles that follow are checked to carry no pulse.

// File: rtl/sir_unwrap_pkg.sv
// Package: codes and encodings shared by the unwrap filter.
// Assumes 8-bit received bytes; the codes are fixed by the line protocol.
package sir_unwrap_pkg;
    localparam logic [7:0] FRAME_START = 8'hC0;
    localparam logic [7:0] FRAME_END   = 8'hC1;
    localparam logic [7:0] ESC_CODE    = 8'h7D;
    localparam logic [7:0] ESC_FLIP    = 8'h20;

    localparam int FLAG_W      = 2;
    localparam int FLAG_LENERR = 0;
    localparam int FLAG_NOEND  = 1;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_OPEN = 2'd1,
        ST_ESC  = 2'd2
    } unwrap_state_t;
endpackage

// File: rtl/sir_byte_class.sv
// Module: sir_byte_class
// Decodes one received byte into delimiter and escape classes.
// Assumes the codes are distinct constants from the package.
module sir_byte_class
    import sir_unwrap_pkg::*;
(
    input  logic [7:0] byte_in,
    output logic       is_start,
    output logic       is_end,
    output logic       is_esc
);
    // Compare the byte against each fixed code.
    always_comb begin
        is_start = (byte_in == FRAME_START);
        is_end   = (byte_in == FRAME_END);
        is_esc   = (byte_in == ESC_CODE);
    end
endmodule

// File: rtl/sir_len_counter.sv
// Module: sir_len_counter
// Counts accepted payload bytes up to a programmable limit; flags overflow.
// Assumes clear and step are never requested in the same cycle.
module sir_len_counter #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] count,
    output logic             over,
    output logic             accept
);
    // A step is taken only while the count is below the limit.
    always_comb accept = step && (count < limit);

    // Count register and sticky over-limit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            over  <= 1'b0;
        end else if (clear) begin
            count <= '0;
            over  <= 1'b0;
        end else if (accept) begin
            count <= count + 1'b1;
        end else if (step) begin
            over  <= 1'b1;
        end
    end

    // R6: the count only moves by one step up or back to zero.
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));

    // R10: the over flag is only raised when the limit was already reached.
    assert_over_at_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(over) |-> ($past(count) >= $past(limit)));
endmodule

// File: rtl/sir_unwrap.sv
// Module: sir_unwrap
// Frame unwrap filter for the slow-rate infrared receive path: strips
// header, delimiters and escapes, forwards payload with start and end
// markers, counts bytes and reports per-frame error flags.
// Assumes at most one input byte per cycle; all outputs are registered.
module sir_unwrap
    import sir_unwrap_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              sir_mode,
    input  logic              filt_test,
    input  logic [LEN_W-1:0]  max_len,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic [LEN_W-1:0]  byte_count,
    output logic [LEN_W-1:0]  end_len,
    output logic [FLAG_W-1:0] end_flags,
    output logic [15:0]       delim_word
);
    unwrap_state_t state, state_nxt;
    logic is_start, is_end, is_esc;
    logic enabled, has_content;
    logic cnt_clear, cnt_step, cnt_over, cnt_accept;
    logic close_frame, missing_end;
    logic [7:0] payload;

    sir_byte_class u_class (
        .byte_in  (in_byte),
        .is_start (is_start),
        .is_end   (is_end),
        .is_esc   (is_esc)
    );

    sir_len_counter #(.LEN_W(LEN_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .step   (cnt_step),
        .limit  (max_len),
        .count  (byte_count),
        .over   (cnt_over),
        .accept (cnt_accept)
    );

    // Fixed delimiter readback: start code low byte, end code high byte.
    always_comb delim_word = {FRAME_END, FRAME_START};

    // Enable, frame-content test and unescaped payload value.
    always_comb begin
        enabled     = sir_mode || filt_test;
        has_content = (byte_count != '0) || cnt_over;
        payload     = (state == ST_ESC) ? (in_byte ^ ESC_FLIP) : in_byte;
    end

    // Next-state and action decode for one received byte.
    always_comb begin
        state_nxt   = state;
        cnt_clear   = 1'b0;
        cnt_step    = 1'b0;
        close_frame = 1'b0;
        missing_end = 1'b0;
        if (in_valid) begin
            if (!enabled) begin
                state_nxt = ST_HUNT;
            end else if (state == ST_HUNT) begin
                if (is_start) begin
                    cnt_clear = 1'b1;
                    state_nxt = ST_OPEN;
                end
            end else if (is_start) begin
                close_frame = has_content;
                missing_end = 1'b1;
                cnt_clear   = 1'b1;
                state_nxt   = ST_OPEN;
            end else if (is_end) begin
                close_frame = has_content;
                state_nxt   = ST_HUNT;
            end else if (state == ST_OPEN && is_esc) begin
                state_nxt = ST_ESC;
            end else begin
                cnt_step  = 1'b1;
                state_nxt = ST_OPEN;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // Registered payload stream and end-of-frame report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            end_len   <= '0;
            end_flags <= '0;
        end else begin
            out_valid <= cnt_accept;
            out_sof   <= cnt_accept && (byte_count == '0);
            out_eof   <= close_frame;
            if (cnt_accept) out_data <= payload;
            if (close_frame) begin
                end_len                 <= byte_count;
                end_flags[FLAG_LENERR]  <= cnt_over;
                end_flags[FLAG_NOEND]   <= missing_end;
            end
        end
    end

    // R4: a start flag only accompanies a forwarded byte.
    assert_sof_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R7: the end marker never shares a cycle with a data byte.
    assert_eof_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> !out_valid);

    // R8: no end marker for an empty, error-free frame.
    assert_no_empty_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (end_len != '0 || end_flags[FLAG_LENERR]));

    // R10: a forwarded byte never takes the count past the limit.
    assert_within_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (byte_count <= $past(max_len)));

    // R11: a byte seen while disabled produces no pulse.
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sir_mode && !filt_test) |=> (!out_valid && !out_eof));
endmodule

// File: tb/sir_unwrap_test.sv
module sir_unwrap_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic sir_mode = 1'b1;
    logic filt_test = 1'b0;
    logic [LW-1:0] max_len = 12'd100;
    logic out_valid, out_sof, out_eof;
    logic [7:0] out_data;
    logic [LW-1:0] byte_count, end_len;
    logic [1:0] end_flags;
    logic [15:0] delim_word;

    int checks = 0;
    int errors = 0;

    // model of expected behaviour, built from the requirements
    int m_state = 0;          // 0 outside, 1 open, 2 after escape
    int m_cnt = 0;
    bit m_over = 0;
    bit e_valid, e_sof, e_eof;
    int e_data, e_len, e_flags;

    sir_unwrap #(.LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .sir_mode(sir_mode), .filt_test(filt_test), .max_len(max_len),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .byte_count(byte_count), .end_len(end_len),
        .end_flags(end_flags), .delim_word(delim_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input logic [7:0] b);
        e_valid = 0; e_sof = 0; e_eof = 0;
        if (!(sir_mode || filt_test)) begin
            m_state = 0;
        end else if (m_state == 0) begin
            if (b == 8'hC0) begin m_state = 1; m_cnt = 0; m_over = 0; end
        end else if (b == 8'hC0) begin
            if (m_cnt != 0 || m_over) begin
                e_eof = 1; e_len = m_cnt; e_flags = 2 + int'(m_over);
            end
            m_cnt = 0; m_over = 0; m_state = 1;
        end else if (b == 8'hC1) begin
            if (m_cnt != 0 || m_over) begin
                e_eof = 1; e_len = m_cnt; e_flags = int'(m_over);
            end
            m_state = 0;
        end else if (m_state == 1 && b == 8'h7D) begin
            m_state = 2;
        end else begin
            int d;
            d = (m_state == 2) ? int'(b ^ 8'h20) : int'(b);
            m_state = 1;
            if (m_cnt < int'(max_len)) begin
                e_valid = 1; e_data = d; e_sof = (m_cnt == 0); m_cnt++;
            end else begin
                m_over = 1;
            end
        end
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = b;
        model_step(b);
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(tag, "out_valid", int'(out_valid), int'(e_valid));
        if (e_valid) begin
            chk(tag, "out_data", int'(out_data), e_data);
            chk(tag, "out_sof", int'(out_sof), int'(e_sof));
        end
        chk(tag, "out_eof", int'(out_eof), int'(e_eof));
        if (e_eof) begin
            chk(tag, "end_len", int'(end_len), e_len);
            chk(tag, "end_flags", int'(end_flags), e_flags);
        end
        chk(tag, "byte_count", int'(byte_count), m_cnt);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R7", "idle out_eof", int'(out_eof), 0);
        chk("R4", "idle out_valid", int'(out_valid), 0);
    endtask

    // send a payload byte, escaping it when it collides with a code
    task automatic send_pay(input logic [7:0] v, input string tag);
        if (v == 8'hC0 || v == 8'hC1 || v == 8'h7D) begin
            send(8'h7D, tag);
            send(v ^ 8'h20, tag);
        end else begin
            send(v, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R1 reset state
        chk("R1", "reset out_valid", int'(out_valid), 0);
        chk("R1", "reset out_eof", int'(out_eof), 0);
        chk("R1", "reset byte_count", int'(byte_count), 0);
        // R2 delimiter readback
        chk("R2", "delim_word", int'(delim_word), 16'hC1C0);

        // R3 header fill outside a frame, then a plain frame
        send(8'hFF, "R3"); send(8'h11, "R3"); send(8'hC1, "R3");
        send(8'hC0, "R4"); send(8'h41, "R4"); send(8'h42, "R4");
        send(8'h43, "R6"); send(8'hC1, "R7");
        idle();
        send(8'hFF, "R3");
        chk("R3", "count held after frame", int'(byte_count), 3);

        // R5 exhaustive single-byte payload, escaped where needed
        for (int v = 0; v < 256; v++) begin
            send(8'hC0, "R5");
            send_pay(8'(v), "R5");
            send(8'hC1, "R7");
        end

        // R8 R10 sweep of limit against frame length with repeated starts
        for (int ml = 0; ml < 5; ml++) begin
            for (int n = 0; n < 6; n++) begin
                max_len = 12'(ml);
                send(8'hFF, "R3");
                send(8'hC0, "R8"); send(8'hC0, "R8");
                for (int i = 0; i < n; i++) send_pay(8'h7B + 8'(i), "R10");
                send(8'hC1, "R10");
                idle();
            end
        end
        max_len = 12'd100;

        // R9 missing end: start inside an open frame
        for (int n = 1; n < 5; n++) begin
            send(8'hC0, "R9");
            for (int i = 0; i < n; i++) send(8'h30 + 8'(i), "R9");
            send(8'hC0, "R9");
            chk("R9", "count restarted", int'(byte_count), 0);
            send(8'h55, "R9");
            send(8'hC1, "R9");
        end

        // R11 test bit alone enables, both low disables
        sir_mode = 1'b0; filt_test = 1'b1;
        send(8'hC0, "R11"); send(8'h66, "R11"); send(8'hC1, "R11");
        send(8'hC0, "R11"); send(8'h67, "R11");
        filt_test = 1'b0;
        send(8'h68, "R11"); send(8'hC0, "R11"); send(8'h69, "R11");
        chk("R11", "disabled no data", int'(out_valid), 0);
        sir_mode = 1'b1;
        send(8'h6A, "R11"); send(8'hC1, "R11");
        chk("R11", "abandoned frame no end", int'(out_eof), 0);

        // R12 delimiter right after escape
        send(8'hC0, "R12"); send(8'h21, "R12"); send(8'h7D, "R12"); send(8'hC1, "R12");
        chk("R12", "end after escape", int'(out_eof), 1);
        send(8'hC0, "R12"); send(8'h22, "R12"); send(8'h7D, "R12"); send(8'hC0, "R12");
        chk("R12", "start after escape flags", int'(end_flags), 2);
        send(8'h23, "R12"); send(8'hC1, "R12");
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule